// File: doc/BRIEF.md
# Segment-Decoded Direct-Mapped Instruction Cache

This block is an instruction-fetch cache for a 32-bit processor, placed between the fetch stage and main memory. The top byte of each fetch address selects the segment. Only two segments are cached: segment 0x00 and segment 0x80. Every other segment, including 0xA0 and above, is read straight from memory. Cached fetches look up a 4 KB direct-mapped store that keeps a 24-bit tag beside every 32-bit word. A miss refills the whole aligned four-word line from memory.

An isolate input suppresses refills, so a miss then returns the memory word and leaves the store untouched. An invalidate pulse clears the store one word per cycle. During the clear, new fetches are held off.

Hits never consult memory. A hit therefore returns the word that was captured at refill time, even if memory at that address has been rewritten since. The tag holds only the low 24 address bits, so the same offset in segment 0x00 and in segment 0x80 shares one entry.

Top module: `seg_icache`

## Requirements
- R1: A fetch whose address bits [31:24] are neither 0x00 nor 0x80 performs exactly one memory read at the requested address. Its response carries the memory word with `rsp_hit_o` = 0. Repeating the fetch reads memory again.
- R2: A cacheable miss with `isolate_i` low issues four memory reads at line base + 0, 4, 8 and 12, in ascending order. The line base is the address with bits [3:0] cleared. The response is the word read at the requested address, with `rsp_hit_o` = 0.
- R3: After a refill, a cacheable fetch to any word of that line performs no memory read. It returns the word captured at refill with `rsp_hit_o` = 1.
- R4: A hit returns the word captured at refill even when memory at that address has changed since.
- R5: A cacheable miss with `isolate_i` high performs one memory read at the requested address and returns that word. Store contents stay unchanged, so a line that was resident before still hits afterwards.
- R6: The entry is chosen by address bits [11:2] and tagged with bits [23:0]. Two addresses with equal bits [23:0] in segments 0x00 and 0x80 hit on the same entry. Two addresses with equal bits [11:2] but different bits [23:12] evict each other.
- R7: After reset, and after a one-cycle `inval_i` pulse, `fetch_ready_o` stays low while the 1024 word entries are cleared one per cycle. After a pulse accepted while idle this lasts exactly 1024 cycles. Afterwards every previously filled line misses.
- R8: Each accepted fetch (`fetch_req_i` and `fetch_ready_o` high at an edge) produces exactly one single-cycle `rsp_valid_o` pulse. `fetch_ready_o` is low in the cycle after acceptance. `mem_req_o` and `mem_addr_o` hold steady until `mem_valid_i` is seen.
- R9: A hit raises `rsp_valid_o` in the second cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a full clear |
| inval_i | input | 1 | Invalidate pulse: clear every tag and data word to all ones |
| isolate_i | input | 1 | Sampled with a fetch; when high, a miss does not refill |
| fetch_req_i | input | 1 | Fetch request, taken when `fetch_ready_o` is high |
| fetch_addr_i | input | 32 | Word-aligned fetch address |
| fetch_ready_o | output | 1 | The cache can take a fetch this cycle |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | 32 | Instruction word returned |
| rsp_hit_o | output | 1 | Response was served from the store |
| mem_req_o | output | 1 | Memory read request, held until `mem_valid_i` |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_valid_i | input | 1 | Memory read data valid, one pulse per read |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The assertions assume that `mem_valid_i` pulses for one cycle only while `mem_req_o` is high, with at most one pulse per read. They also assume that fetch addresses are word-aligned, so no fetch offset can equal an all-ones tag. The bench's memory responder answers only a pending request, after a random delay of zero to two cycles, and drops its strobe on the next cycle. Every address, random or directed, is built with bits [1:0] at zero.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // controller states
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_LOOKUP,
    ST_BYPASS,
    ST_REFILL
  } sic_state_e;

  // segments served from the store
  localparam logic [7:0] SEG_CACHED_LO = 8'h00;
  localparam logic [7:0] SEG_CACHED_HI = 8'h80;
endpackage

// File: rtl/sic_sdp_ram.sv
// Simple dual-port RAM, one write port and one registered read port.
module sic_sdp_ram #(
  parameter int AW = 10,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_val
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_val <= mem[rd_idx];
  end
endmodule

// File: rtl/sic_region.sv
// Segment decode: only two segment values are cacheable.
module sic_region #(
  parameter int           SEG_W = 8,
  parameter logic [SEG_W-1:0] SEG_A = '0,
  parameter logic [SEG_W-1:0] SEG_B = '0
) (
  input  logic [SEG_W-1:0] seg,
  output logic             cacheable
);
  always_comb cacheable = (seg == SEG_A) || (seg == SEG_B);
endmodule

// File: rtl/sic_ctrl.sv
// Fetch controller: lookup, bypass read, line refill and clear sequencing.
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SEG_W      = 8,
  parameter int IDX_W      = 12,
  parameter int LINE_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inval_i,
  input  logic                isolate_i,
  input  logic                fetch_req_i,
  input  logic [ADDR_W-1:0]   fetch_addr_i,
  input  logic                cacheable_i,
  output logic                fetch_ready_o,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  output logic                rsp_hit_o,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_valid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                rd_en_o,
  output logic [IDX_W-$clog2(DATA_W/8)-1:0] rd_idx_o,
  input  logic [ADDR_W-SEG_W-1:0] rd_tag_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                wr_en_o,
  output logic [IDX_W-$clog2(DATA_W/8)-1:0] wr_idx_o,
  output logic [ADDR_W-SEG_W-1:0] wr_tag_o,
  output logic [DATA_W-1:0]   wr_data_o
);
  localparam int BYTE_OFF = $clog2(DATA_W/8);
  localparam int WORD_AW  = IDX_W - BYTE_OFF;
  localparam int LINE_AW  = $clog2(LINE_WORDS);
  localparam int LINE_LSB = BYTE_OFF + LINE_AW;
  localparam int TAG_W    = ADDR_W - SEG_W;
  localparam logic [WORD_AW-1:0] CLR_LAST  = '1;
  localparam logic [LINE_AW-1:0] BEAT_LAST = LINE_AW'(LINE_WORDS - 1);

  sic_state_e          state;
  logic [ADDR_W-1:0]   req_addr;
  logic                req_iso;
  logic                inval_pend;
  logic [WORD_AW-1:0]  clr_cnt;
  logic [LINE_AW-1:0]  beat;
  logic [DATA_W-1:0]   fill_word;
  logic                accept;
  logic                beat_is_req;

  always_comb fetch_ready_o = (state == ST_IDLE) && !inval_pend && !inval_i;
  always_comb accept        = fetch_ready_o && fetch_req_i;
  always_comb rd_en_o       = accept;
  always_comb rd_idx_o      = fetch_addr_i[IDX_W-1:BYTE_OFF];
  always_comb beat_is_req   = (beat == req_addr[LINE_LSB-1:BYTE_OFF]);

  // store write port: clear sweep or refill beats
  always_comb begin
    wr_en_o   = 1'b0;
    wr_idx_o  = clr_cnt;
    wr_tag_o  = '1;
    wr_data_o = '1;
    if (state == ST_CLEAR) begin
      wr_en_o = 1'b1;
    end else if (state == ST_REFILL && mem_valid_i) begin
      wr_en_o   = 1'b1;
      wr_idx_o  = {req_addr[IDX_W-1:LINE_LSB], beat};
      wr_tag_o  = {req_addr[TAG_W-1:LINE_LSB], beat, {BYTE_OFF{1'b0}}};
      wr_data_o = mem_rdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_CLEAR;
      clr_cnt     <= '0;
      inval_pend  <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_hit_o   <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
      req_addr    <= '0;
      req_iso     <= 1'b0;
      beat        <= '0;
      fill_word   <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (inval_i) inval_pend <= 1'b1;
      case (state)
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == CLR_LAST) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (inval_i || inval_pend) begin
            state      <= ST_CLEAR;
            clr_cnt    <= '0;
            inval_pend <= 1'b0;
          end else if (fetch_req_i) begin
            req_addr <= fetch_addr_i;
            req_iso  <= isolate_i;
            if (cacheable_i) begin
              state <= ST_LOOKUP;
            end else begin
              state      <= ST_BYPASS;
              mem_req_o  <= 1'b1;
              mem_addr_o <= fetch_addr_i;
            end
          end
        end
        ST_LOOKUP: begin
          if (rd_tag_i == req_addr[TAG_W-1:0]) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= rd_data_i;
            rsp_hit_o   <= 1'b1;
            state       <= ST_IDLE;
          end else if (req_iso) begin
            state      <= ST_BYPASS;
            mem_req_o  <= 1'b1;
            mem_addr_o <= req_addr;
          end else begin
            state      <= ST_REFILL;
            beat       <= '0;
            mem_req_o  <= 1'b1;
            mem_addr_o <= {req_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
          end
        end
        ST_BYPASS: begin
          if (mem_valid_i) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= mem_rdata_i;
            rsp_hit_o   <= 1'b0;
            mem_req_o   <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        ST_REFILL: begin
          if (mem_valid_i) begin
            if (beat_is_req) fill_word <= mem_rdata_i;
            if (beat == BEAT_LAST) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= beat_is_req ? mem_rdata_i : fill_word;
              rsp_hit_o   <= 1'b0;
              mem_req_o   <= 1'b0;
              state       <= ST_IDLE;
            end else begin
              beat       <= beat + 1'b1;
              mem_addr_o <= mem_addr_o + ADDR_W'(DATA_W/8);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_icache.sv
// Segment-decoded direct-mapped instruction cache, top level.
module seg_icache
  import sic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SEG_W      = 8,
  parameter int IDX_W      = 12,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval_i,
  input  logic              isolate_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_hit_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_OFF = $clog2(DATA_W/8);
  localparam int WORD_AW  = IDX_W - BYTE_OFF;
  localparam int TAG_W    = ADDR_W - SEG_W;

  logic               cacheable;
  logic               rd_en, wr_en;
  logic [WORD_AW-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0]   rd_tag, wr_tag;
  logic [DATA_W-1:0]  rd_data, wr_data;

  sic_region #(
    .SEG_W (SEG_W),
    .SEG_A (SEG_W'(SEG_CACHED_LO)),
    .SEG_B (SEG_W'(SEG_CACHED_HI))
  ) u_region (
    .seg       (fetch_addr_i[ADDR_W-1 -: SEG_W]),
    .cacheable (cacheable)
  );

  sic_sdp_ram #(.AW(WORD_AW), .W(TAG_W)) u_tag_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_tag),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_val (rd_tag)
  );

  sic_sdp_ram #(.AW(WORD_AW), .W(DATA_W)) u_data_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_data),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_val (rd_data)
  );

  sic_ctrl #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SEG_W      (SEG_W),
    .IDX_W      (IDX_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .inval_i       (inval_i),
    .isolate_i     (isolate_i),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .cacheable_i   (cacheable),
    .fetch_ready_o (fetch_ready_o),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_data_o    (rsp_data_o),
    .rsp_hit_o     (rsp_hit_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_valid_i   (mem_valid_i),
    .mem_rdata_i   (mem_rdata_i),
    .rd_en_o       (rd_en),
    .rd_idx_o      (rd_idx),
    .rd_tag_i      (rd_tag),
    .rd_data_i     (rd_data),
    .wr_en_o       (wr_en),
    .wr_idx_o      (wr_idx),
    .wr_tag_o      (wr_tag),
    .wr_data_o     (wr_data)
  );
endmodule

// File: rtl/sic_checker.sv
// Port-level properties for seg_icache, attached through bind.
module sic_checker (
  input logic        clk,
  input logic        rst,
  input logic        fetch_req_i,
  input logic [31:0] fetch_addr_i,
  input logic        fetch_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_hit_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_valid_i
);
  logic        accept;
  logic [27:0] line_q;

  always_comb accept = fetch_req_i && fetch_ready_o;

  always_ff @(posedge clk) begin
    if (rst)         line_q <= '0;
    else if (accept) line_q <= fetch_addr_i[31:4];
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> !rsp_valid_o);                                  // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !fetch_ready_o);                                     // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R8
  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_hit_o) |-> $past(accept, 2));               // R9
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_hit_o) |-> !$past(mem_req_o));              // R3
  AST_HIT_SEGMENT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_hit_o) |-> (line_q[27:20] == 8'h00 || line_q[27:20] == 8'h80)); // R1
  AST_MEM_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[31:4] == line_q));                    // R2
endmodule

bind seg_icache sic_checker u_sic_checker (
  .clk           (clk),
  .rst           (rst),
  .fetch_req_i   (fetch_req_i),
  .fetch_addr_i  (fetch_addr_i),
  .fetch_ready_o (fetch_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_hit_o     (rsp_hit_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_valid_i   (mem_valid_i)
);

// File: tb/seg_icache_bench.sv
module seg_icache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inval_i = 1'b0;
  logic        isolate_i = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_ready_o, rsp_valid_o, rsp_hit_o, mem_req_o;
  logic [31:0] rsp_data_o, mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #10 clk = ~clk;

  seg_icache u_seg_icache (
    .clk (clk), .rst (rst), .inval_i (inval_i), .isolate_i (isolate_i),
    .fetch_req_i (fetch_req_i), .fetch_addr_i (fetch_addr_i),
    .fetch_ready_o (fetch_ready_o), .rsp_valid_o (rsp_valid_o),
    .rsp_data_o (rsp_data_o), .rsp_hit_o (rsp_hit_o),
    .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
    .mem_valid_i (mem_valid_i), .mem_rdata_i (mem_rdata_i)
  );

  int          checks = 0;
  int          errors = 0;
  logic [31:0] epoch = 0;
  logic [31:0] rd_log [8];
  int          rd_cnt = 0;
  int          wait_cnt = 0;
  logic [23:0] sh_tag  [1024];
  logic [31:0] sh_data [1024];
  logic [31:0] sh_ep   [1024];

  function automatic logic [31:0] memval(input logic [31:0] a, input logic [31:0] ep);
    return {a[31:2], 2'b00} ^ 32'h5A3C_0000 ^ (ep * 32'h9E37_79B1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic shadow_clear();
    for (int i = 0; i < 1024; i++) begin
      sh_tag[i] = '1; sh_data[i] = '1; sh_ep[i] = '0;
    end
  endtask

  // memory responder: answers a pending read after 0..2 cycles, one-cycle strobe
  initial begin
    forever begin
      @(negedge clk);
      if (mem_valid_i) begin
        mem_valid_i = 1'b0;
      end else if (mem_req_o) begin
        if (wait_cnt == 0) begin
          mem_valid_i = 1'b1;
          mem_rdata_i = memval(mem_addr_o, epoch);
          if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr_o;
          rd_cnt++;
          wait_cnt = $urandom % 3;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, input bit iso, output bit got_hit);
    bit          cache, exp_hit;
    int          exp_rd, lat;
    logic [9:0]  idx;
    logic [31:0] exp_data;
    string       rq;
    idx   = a[11:2];
    cache = (a[31:24] == 8'h00) || (a[31:24] == 8'h80);
    exp_hit = 1'b0;
    exp_data = memval(a, epoch);
    if (!cache) begin
      rq = "R1"; exp_rd = 1;
    end else if (sh_tag[idx] == a[23:0]) begin
      rq = (sh_ep[idx] != epoch) ? "R4" : "R3";
      exp_hit = 1'b1; exp_rd = 0; exp_data = sh_data[idx];
    end else if (iso) begin
      rq = "R5"; exp_rd = 1;
    end else begin
      rq = "R2"; exp_rd = 4;
      for (int k = 0; k < 4; k++) begin
        sh_tag[{idx[9:2], 2'(k)}]  = {a[23:4], 2'(k), 2'b00};
        sh_data[{idx[9:2], 2'(k)}] = memval({a[31:4], 2'(k), 2'b00}, epoch);
        sh_ep[{idx[9:2], 2'(k)}]   = epoch;
      end
    end
    @(negedge clk);
    while (!fetch_ready_o) @(negedge clk);
    rd_cnt = 0;
    fetch_req_i = 1'b1; fetch_addr_i = a; isolate_i = iso;
    @(posedge clk);
    @(negedge clk);
    fetch_req_i = 1'b0; isolate_i = 1'b0;
    lat = 1;
    while (!rsp_valid_o && lat < 200) begin
      @(negedge clk); lat++;
    end
    got_hit = rsp_hit_o;
    chk(rsp_valid_o == 1'b1, rq, "response", 32'(rsp_valid_o), 1);
    chk(rsp_data_o == exp_data, rq, "data", rsp_data_o, exp_data);
    chk(rsp_hit_o == exp_hit, rq, "hit flag", 32'(rsp_hit_o), 32'(exp_hit));
    chk(rd_cnt == exp_rd, rq, "memory reads", rd_cnt, exp_rd);
    if (exp_rd == 1) chk(rd_log[0] == a, rq, "read address", rd_log[0], a);
    if (exp_rd == 4 && rd_cnt == 4)
      for (int k = 0; k < 4; k++)
        chk(rd_log[k] == {a[31:4], 2'(k), 2'b00}, "R2", "refill order",
            rd_log[k], {a[31:4], 2'(k), 2'b00});
    if (exp_hit) chk(lat == 2, "R9", "hit latency", lat, 2);
    @(negedge clk);
    chk(!rsp_valid_o, "R8", "strobe width", 32'(rsp_valid_o), 0);
    chk(!mem_req_o, "R8", "memory idle", 32'(mem_req_o), 0);
  endtask

  task automatic do_inval();
    int n;
    @(negedge clk);
    while (!fetch_ready_o) @(negedge clk);
    inval_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inval_i = 1'b0;
    n = 0;
    while (!fetch_ready_o && n < 5000) begin
      n++; @(negedge clk);
    end
    chk(n == 1024, "R7", "clear cycles", n, 1024);
    shadow_clear();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit h;
    int n;
    logic [7:0] segs [8];
    logic [31:0] a;
    segs = '{8'h00, 8'h80, 8'h00, 8'h80, 8'hA0, 8'hBF, 8'h1F, 8'hC0};
    void'($urandom(32'h00C0FFEE));
    shadow_clear();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!fetch_ready_o, "R7", "ready in reset", 32'(fetch_ready_o), 0);
    chk(!rsp_valid_o, "R8", "rsp in reset", 32'(rsp_valid_o), 0);
    chk(!mem_req_o, "R8", "mem req in reset", 32'(mem_req_o), 0);
    rst = 1'b0;
    n = 0;
    while (!fetch_ready_o && n < 3000) begin
      n++; @(negedge clk);
    end
    chk(n >= 1024 && n < 3000, "R7", "post-reset clear length", n, 1024);

    // directed
    do_fetch(32'h0000_0104, 1'b0, h);                       // R2 miss, second word
    do_fetch(32'h0000_0108, 1'b0, h);                       // R3 hit
    do_fetch(32'h8000_0100, 1'b0, h);                       // R6 other segment shares entry
    chk(h, "R6", "segment alias hit", 32'(h), 1);
    epoch = epoch + 1;
    do_fetch(32'h0000_010C, 1'b0, h);                       // R4 stale hit
    do_fetch(32'h0000_110C, 1'b1, h);                       // R5 isolated miss
    do_fetch(32'h0000_010C, 1'b0, h);
    chk(h, "R5", "entry kept after isolated miss", 32'(h), 1);
    do_fetch(32'h0000_1100, 1'b0, h);                       // R6 evict
    do_fetch(32'h0000_0100, 1'b0, h);
    chk(!h, "R6", "evicted line misses", 32'(h), 0);
    do_fetch(32'h0000_020C, 1'b0, h);                       // R2 last beat requested
    do_fetch(32'hA000_0100, 1'b0, h);                       // R1
    do_fetch(32'hA000_0100, 1'b0, h);
    chk(!h, "R1", "uncached never fills", 32'(h), 0);
    do_fetch(32'hBFC0_0000, 1'b0, h);                       // R1
    do_fetch(32'h1F00_0010, 1'b0, h);                       // R1
    do_inval();
    do_fetch(32'h0000_0100, 1'b0, h);
    chk(!h, "R7", "miss after invalidate", 32'(h), 0);

    // random
    for (int i = 0; i < 400; i++) begin
      a = {segs[$urandom % 8], 10'd0, 2'($urandom % 3), 4'd0,
           4'($urandom % 6), 2'($urandom % 4), 2'b00};
      do_fetch(a, ($urandom % 6) == 0, h);
      if (i % 37 == 36) epoch = epoch + 1;
      if (i % 150 == 149) do_inval();
    end
    finish_run();
  end
endmodule